// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a slave-only SMBus target that holds a small bank of 8-bit control registers for a clock generator. The registers drive its output-enable, spread-spectrum and test-request pins. The block runs on a system clock and brings SCL and SDA in through synchronisers. It finds START and STOP conditions on the resynchronised lines and drives SDA only by pulling it low, for its own ACKs and for read data.

Every access has the same shape. The master sends the device address and the direction bit, then a starting register offset, then a byte count N. In the write direction the master then sends N data bytes. In the read direction the slave then returns N data bytes. The register pointer steps by one after each data byte. Offsets that have no register behind them read as zero and drop writes. A write with a count of zero is refused at the count byte.

Top module: `clkctl_smb_slave`

## Requirements
- R1: The slave ACKs an address byte whose upper seven bits equal 1101001. Bit 0 of that byte selects the direction: 0 is write, 1 is read. Any other address gets no ACK, and the slave then ignores the bus until the next START.
- R2: In the write direction the slave ACKs the offset byte, the count byte and each of the first N data bytes. It stores each of those data bytes. It NACKs any data byte after the N-th and does not store it.
- R3: The first data byte goes to the register at the offset, and each later byte goes to the next offset up.
- R4: A write whose count byte is zero gets a NACK on that count byte. The slave NACKs any data bytes that follow, and no register changes.
- R5: Register 0 resets to 0x1F. Its bits 0..4 drive `src_oe[0..4]`, and bits 5..7 are spare storage.
- R6: Register 1 resets to 0xF6. Bit 0 drives `spread_on`. Bits 1, 2, 4 and 5 drive `cpu_oe[0..3]`, bits 6 and 7 drive `ref_oe[0..1]`, and bit 3 is spare storage.
- R7: Register 2 resets to 0xFF. Bit 0 drives `usb_oe`, bits 1..3 drive `pcif_oe[0..2]`, and bits 4..7 drive `pci_oe[0..3]`. Register 6 resets to 0x00, and its bit 6 drives `test_req`.
- R8: In the read direction the slave ACKs the offset and count bytes. It then sends N bytes, most significant bit first, from successive offsets. It stops sending after the N-th byte or after any byte the master NACKs, and leaves SDA released from then on.
- R9: Offsets at or above NUM_REGS read as 0x00. Writes to them are ACKed but change nothing.
- R10: A repeated START restarts address decoding. A STOP at any point returns the slave to idle with SDA released.
- R11: The slave changes `sda_pull` only while SCL is low. The one exception is releasing SDA when it sees a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SMBus clock line as seen at the pad |
| sda_in | input | 1 | SMBus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| src_oe | output | 5 | Serial reference clock output enables |
| cpu_oe | output | 4 | CPU clock output enables |
| ref_oe | output | 2 | Reference clock output enables |
| usb_oe | output | 1 | 48 MHz output enable |
| pcif_oe | output | 3 | Free-running PCI clock enables |
| pci_oe | output | 4 | PCI clock enables |
| spread_on | output | 1 | Spread-spectrum enable |
| test_req | output | 1 | Test-mode request bit |

## Verification
The bench builds the block with NUM_REGS at 8 and a two-stage synchroniser. With eight registers, the test-request bit in register 6 and the spare register 7 can both be reached. Offsets 8 and above are then out of range, so a block write that starts at 7 runs off the end of the bank, and reads at offset 10 must return zero. The SCL half-period is 16 system clocks, which leaves enough margin around the synchroniser delay to time ACK release and read data across repeated STARTs and aborted transfers.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_OFFS,
      ST_CNT,
      ST_WDATA,
      ST_ACK,
      ST_RDATA,
      ST_RACK
   } smb_state_e;

   localparam int BYTE_W = 8;

   // Power-up image of each control register
   function automatic logic [7:0] reset_val(input int idx);
      case (idx)
         0:       reset_val = 8'h1F;
         1:       reset_val = 8'hF6;
         2:       reset_val = 8'hFF;
         default: reset_val = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_prev;
   logic              sda_prev;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_prev;
   assign scl_fall  = ~scl_s & scl_prev;
   assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
   parameter int NUM_REGS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [7:0]            wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [7:0]            rd_addr,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] regs_flat
);
   logic [7:0] regs [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] RST = clkctl_pkg::reset_val(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[g] <= RST;
         else if (wr_en && wr_addr == 8'(g))
            regs[g] <= wr_data;
      end
      assign regs_flat[g*8 +: 8] = regs[g];
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_addr == 8'(i)) rd_data = regs[i];
   end

   AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && 32'(wr_addr) >= NUM_REGS) |=> $stable(regs_flat)); // R9

endmodule

// File: rtl/smb_idx_fsm.sv
module smb_idx_fsm
   import clkctl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic [7:0] rd_data,
   output logic       sda_pull,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data,
   output logic [7:0] ptr
);
   smb_state_e st, nxt_st;
   logic [3:0] bitcnt;
   logic [7:0] shreg;
   logic [7:0] remain;
   logic       rw;
   logic       mack;
   logic       byte_done;

   assign byte_done = scl_fall && (bitcnt == 4'd8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         nxt_st   <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         remain   <= '0;
         rw       <= 1'b0;
         mack     <= 1'b0;
         ptr      <= '0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
         end else if (start_det) begin
            st       <= ST_ADDR;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_OFFS, ST_CNT, ST_WDATA: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (byte_done) begin
                     bitcnt <= '0;
                     case (st)
                        ST_ADDR: begin
                           if (shreg[7:1] == DEV_ADDR) begin
                              rw       <= shreg[0];
                              sda_pull <= 1'b1;
                              st       <= ST_ACK;
                              nxt_st   <= ST_OFFS;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        ST_OFFS: begin
                           ptr      <= shreg;
                           sda_pull <= 1'b1;
                           st       <= ST_ACK;
                           nxt_st   <= ST_CNT;
                        end
                        ST_CNT: begin
                           if (!rw && shreg == 8'h00) begin
                              st <= ST_IDLE;
                           end else begin
                              remain   <= shreg;
                              sda_pull <= 1'b1;
                              st       <= ST_ACK;
                              nxt_st   <= rw ? ST_RDATA : ST_WDATA;
                           end
                        end
                        default: begin
                           if (remain != 8'h00) begin
                              wr_en    <= 1'b1;
                              wr_addr  <= ptr;
                              wr_data  <= shreg;
                              ptr      <= ptr + 8'd1;
                              remain   <= remain - 8'd1;
                              sda_pull <= 1'b1;
                              st       <= ST_ACK;
                              nxt_st   <= ST_WDATA;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     st       <= nxt_st;
                     if (nxt_st == ST_RDATA) begin
                        if (remain == 8'h00) begin
                           st <= ST_IDLE;
                        end else begin
                           shreg    <= rd_data;
                           sda_pull <= ~rd_data[7];
                        end
                     end
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_pull <= 1'b0;
                        bitcnt   <= '0;
                        ptr      <= ptr + 8'd1;
                        remain   <= remain - 8'd1;
                        st       <= ST_RACK;
                     end else begin
                        shreg    <= {shreg[6:0], 1'b0};
                        sda_pull <= ~shreg[6];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack && remain != 8'h00) begin
                        shreg    <= rd_data;
                        sda_pull <= ~rd_data[7];
                        st       <= ST_RDATA;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull)) |->
         ($past(scl_fall) || ($past(start_det || stop_det) && !sda_pull))); // R11

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_pull && st == ST_IDLE)); // R10

   AST_ADDR_MISMATCH_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && byte_done && shreg[7:1] != DEV_ADDR && !start_det && !stop_det)
         |=> !sda_pull); // R1

   AST_ZERO_COUNT_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CNT && byte_done && !rw && shreg == 8'h00 && !start_det && !stop_det)
         |=> (!sda_pull && !wr_en)); // R4

   AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> sda_pull); // R2

endmodule

// File: rtl/clkctl_smb_slave.sv
module clkctl_smb_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'b1101001,
   parameter int         NUM_REGS    = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       sda_pull,
   output logic [4:0] src_oe,
   output logic [3:0] cpu_oe,
   output logic [1:0] ref_oe,
   output logic       usb_oe,
   output logic [2:0] pcif_oe,
   output logic [3:0] pci_oe,
   output logic       spread_on,
   output logic       test_req
);
   localparam int FLAT_W = NUM_REGS * clkctl_pkg::BYTE_W;

   if (NUM_REGS < 7 || NUM_REGS > 256) begin : g_bad_regs
      $error("NUM_REGS must lie in 7..256");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              wr_en;
   logic [7:0]        wr_addr, wr_data, ptr, rd_data;
   logic [FLAT_W-1:0] regs_flat;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smb_idx_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .rd_data(rd_data), .sda_pull(sda_pull), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .ptr(ptr)
   );

   smb_reg_bank #(.NUM_REGS(NUM_REGS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
      .regs_flat(regs_flat)
   );

   // Field map: byte b, bit k is regs_flat[8*b+k]
   assign src_oe    = regs_flat[4:0];
   assign spread_on = regs_flat[8];
   assign cpu_oe    = {regs_flat[13], regs_flat[12], regs_flat[10], regs_flat[9]};
   assign ref_oe    = regs_flat[15:14];
   assign usb_oe    = regs_flat[16];
   assign pcif_oe   = regs_flat[19:17];
   assign pci_oe    = regs_flat[23:20];
   assign test_req  = regs_flat[54];

   logic unused_bits;
   assign unused_bits = ^{regs_flat[7:5], regs_flat[11], regs_flat[FLAT_W-1:55],
                          regs_flat[53:24]};

endmodule

// File: tb/clkctl_smb_slave_bench.sv
module clkctl_smb_slave_bench;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;
   localparam int NREG       = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_line;
   logic sda_pull;
   logic [4:0] src_oe;
   logic [3:0] cpu_oe;
   logic [1:0] ref_oe;
   logic usb_oe;
   logic [2:0] pcif_oe;
   logic [3:0] pci_oe;
   logic spread_on, test_req;

   int errors = 0;
   int checks = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;
   logic [7:0] img [NREG];
   logic [7:0] wq [$];

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_line = sda_m & ~sda_pull;

   clkctl_smb_slave u_clkctl_smb_slave (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
      .sda_pull(sda_pull), .src_oe(src_oe), .cpu_oe(cpu_oe), .ref_oe(ref_oe),
      .usb_oe(usb_oe), .pcif_oe(pcif_oe), .pci_oe(pci_oe),
      .spread_on(spread_on), .test_req(test_req)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [20:0] exp_pins();
      return {img[0][4:0], img[1][5], img[1][4], img[1][2], img[1][1],
              img[1][7:6], img[2][0], img[2][3:1], img[2][7:4], img[1][0], img[6][6]};
   endfunction

   function automatic logic [20:0] act_pins();
      return {src_oe, cpu_oe, ref_oe, usb_oe, pcif_oe, pci_oe, spread_on, test_req};
   endfunction

   function automatic logic [7:0] mdl_rd(input logic [7:0] a);
      return (int'(a) < NREG) ? img[a] : 8'h00;
   endfunction

   // Per-clock comparison of pins against the model (R5 R6 R7), and R11 monitor
   logic prev_pull = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (cmp_en) chk(act_pins() == exp_pins(), "R5/R6/R7 pins", 32'(act_pins()),
                         32'(exp_pins()));
         if (sda_pull != prev_pull && scl_m) chk(1'b0, "R11 pull moved with SCL high",
                                                 32'(sda_pull), 32'(prev_pull));
         prev_pull = sda_pull;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      cmp_en = 1'b0;
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q + 4);
      cmp_en = 1'b1;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(2 * Q);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      ack = !sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit mack);
      sda_m = 1'b1;
      b = 8'h00;
      for (int i = 0; i < 8; i++) begin
         tick(Q);
         scl_m = 1'b1; tick(Q);
         b = {b[6:0], sda_line}; tick(Q);
         scl_m = 1'b0;
      end
      tick(Q);
      sda_m = !mack; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   // Block write of wq (may hold more bytes than n); model updated per requirement
   task automatic blk_write(input logic [7:0] off, input int n);
      bit ack;
      bus_start();
      send_byte(8'hD2, ack); chk(ack, "R1 addr ack (write)", 32'(ack), 1);
      send_byte(off, ack);   chk(ack, "R2 offset ack", 32'(ack), 1);
      send_byte(8'(n), ack); chk(ack == (n != 0), "R4 count ack", 32'(ack), 32'(n != 0));
      for (int i = 0; i < wq.size(); i++) begin
         logic [7:0] a;
         bit want;
         a = off + 8'(i);
         want = (n != 0) && (i < n);
         send_byte(wq[i], ack);
         chk(ack == want, "R2 data ack", 32'(ack), 32'(want));
         if (want && int'(a) < NREG) img[a] = wq[i];
      end
      bus_stop();
   endtask

   // Block read; master NACKs byte nack_at (or the last); then probes the released line
   task automatic blk_read(input logic [7:0] off, input int n, input int nack_at);
      bit ack;
      logic [7:0] b;
      bus_start();
      send_byte(8'hD3, ack); chk(ack, "R1 addr ack (read)", 32'(ack), 1);
      send_byte(off, ack);   chk(ack, "R8 offset ack", 32'(ack), 1);
      send_byte(8'(n), ack); chk(ack, "R8 count ack", 32'(ack), 1);
      for (int i = 0; i < n && i <= nack_at; i++) begin
         logic [7:0] a;
         a = off + 8'(i);
         recv_byte(b, (i != n - 1) && (i != nack_at));
         chk(b == mdl_rd(a), int'(a) < NREG ? "R3/R8 read data" : "R9 out-of-range read",
             32'(b), 32'(mdl_rd(a)));
      end
      if (nack_at < n - 1) begin
         recv_byte(b, 1'b0);
         chk(b == 8'hFF, "R8 released after master NACK", 32'(b), 32'hFF);
      end
      bus_stop();
   endtask

   initial begin
      img[0] = 8'h1F; img[1] = 8'hF6; img[2] = 8'hFF;
      for (int i = 3; i < NREG; i++) img[i] = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(3);
      cmp_en = 1'b1;
      chk(act_pins() == exp_pins(), "R5/R6/R7 reset pins", 32'(act_pins()), 32'(exp_pins()));
      chk(sda_pull == 1'b0, "R10 idle released", 32'(sda_pull), 0);

      // R2 R3: three-byte write from offset 0, then read it back
      wq = '{8'h05, 8'h0A, 8'hC3};
      blk_write(8'd0, 3);
      chk({src_oe, cpu_oe} == {5'b00101, 4'b0001}, "R5/R6 pins after write",
          32'({src_oe, cpu_oe}), 32'({5'b00101, 4'b0001}));
      blk_read(8'd0, 3, 99);

      // R7: test-request bit
      wq = '{8'h40};
      blk_write(8'd6, 1);
      chk(test_req == 1'b1, "R7 test_req set", 32'(test_req), 1);
      blk_read(8'd5, 3, 99);

      // R4: zero count refused, trailing bytes ignored
      wq = '{8'h00, 8'h00};
      blk_write(8'd0, 0);

      // R1: wrong address ignored until START
      begin
         bit ack;
         bus_start();
         send_byte(8'hA4, ack); chk(!ack, "R1 foreign addr nack", 32'(ack), 0);
         send_byte(8'h00, ack); chk(!ack, "R1 ignored after mismatch", 32'(ack), 0);
         send_byte(8'h01, ack); chk(!ack, "R1 ignored after mismatch", 32'(ack), 0);
         bus_stop();
      end

      // R9: out-of-range write ignored, reads zero
      wq = '{8'hAA};
      blk_write(8'd10, 1);
      blk_read(8'd10, 1, 99);

      // R2: byte beyond count is NACKed and not stored
      wq = '{8'h11, 8'h22};
      blk_write(8'd3, 1);
      blk_read(8'd3, 2, 99);

      // R3 R9: run off the end of the bank
      wq = '{8'h77, 8'h88};
      blk_write(8'd7, 2);
      blk_read(8'd7, 2, 99);

      // R10: repeated START restarts decoding
      begin
         bit ack;
         bus_start();
         send_byte(8'hD2, ack); chk(ack, "R10 first addr ack", 32'(ack), 1);
         send_byte(8'h00, ack); chk(ack, "R10 first offset ack", 32'(ack), 1);
         bus_start();
         send_byte(8'hD2, ack); chk(ack, "R10 restart addr ack", 32'(ack), 1);
         send_byte(8'h02, ack); chk(ack, "R10 restart offset ack", 32'(ack), 1);
         send_byte(8'h01, ack); chk(ack, "R10 restart count ack", 32'(ack), 1);
         send_byte(8'h5A, ack); chk(ack, "R10 restart data ack", 32'(ack), 1);
         img[2] = 8'h5A;
         bus_stop();
      end

      // R10: STOP mid-transfer aborts the rest
      begin
         bit ack;
         bus_start();
         send_byte(8'hD2, ack); chk(ack, "R10 addr ack", 32'(ack), 1);
         send_byte(8'h01, ack); chk(ack, "R10 offset ack", 32'(ack), 1);
         send_byte(8'h02, ack); chk(ack, "R10 count ack", 32'(ack), 1);
         send_byte(8'h99, ack); chk(ack, "R10 data ack", 32'(ack), 1);
         img[1] = 8'h99;
         bus_stop();
         chk(sda_pull == 1'b0, "R10 released after STOP", 32'(sda_pull), 0);
      end
      blk_read(8'd0, 3, 99);

      // R8: master NACKs the second byte early
      blk_read(8'd0, 4, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule